// File: doc/BRIEF.md
# Parallel EEPROM Page Program and Completion Poll Sequencer

This block sits on the host side of a byte-wide parallel EEPROM bus. It accepts one request at a time. A request carries a start address, a byte count from 1 to 128, an optional write-unlock prefix and a completion-check mode. The payload then arrives as a byte stream with a valid/ready handshake, and the block consumes one byte per bus write cycle. It drives active-low chip enable, output enable and write enable with setup, strobe and recovery times set by parameters. Every payload byte lands in the page of the start address.

After the last byte the block waits a settle interval and then confirms that the device has finished its internal programming. Three methods are available. The first re-reads the last written location until bit 7 matches the bit 7 that was written. The second reads repeatedly until two reads in a row return the same bit 6. The third makes no reads and waits the worst-case programming time. A poll that runs past a configurable limit ends the request with a timeout flag. The stream source must supply payload bytes promptly, because the device starts programming on its own when the gap between byte loads grows too long.

Top module: `eeprom_page_prog`

## Requirements
- R1: After reset, req_ready_o is 1, mem_ce_no, mem_oe_no and mem_we_no are 1, and mem_dq_oe_o, done_o and timeout_o are 0.
- R2: When req_unlock_i is 1, exactly three writes come before the payload: data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. When req_unlock_i is 0, the first write is payload byte 0.
- R3: Payload byte k (k from 0) goes to address {start[15:7], (start[6:0]+k) mod 128}, with data in stream order. Exactly req_len_i payload writes are made, and req_len_i lies in 1..128.
- R4: mem_we_no stays low for exactly PULSE_CYC cycles per write, with mem_ce_no low throughout. Between two writes it stays high at least SETUP_CYC+RECOV_CYC cycles. mem_we_no and mem_oe_no are never both low, and while mem_ce_no is high both strobes are high.
- R5: byte_ready_o is high only while the block waits for the next payload byte. Exactly req_len_i bytes are taken from the stream per request.
- R6: In the poll modes, the first read strobe comes at least SETTLE_CYC cycles after the rising edge of the last write strobe.
- R7: Mode 1 (bit-7 poll) reads the last payload address. It finishes when bit 7 read equals bit 7 of the last payload byte.
- R8: Mode 2 (bit-6 poll) finishes only when two reads in a row return the same bit 6, so at least two reads are made.
- R9: Modes 0 and 3 make no reads. done_o comes between WAIT_CYC and WAIT_CYC+RECOV_CYC+3 cycles after the last write strobe rises.
- R10: If a poll read is not ready and at least TIMEOUT_CYC cycles have passed since the last write finished, the request ends with timeout_o high together with done_o. Otherwise timeout_o stays 0.
- R11: done_o is a one-cycle pulse. req_ready_o is low from the cycle after a request is accepted until the cycle after done_o.
- R12: mem_dq_oe_o is 0 whenever mem_oe_no is low. The data bus is driven only in write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_addr_i | input | AW | Start address |
| req_len_i | input | LEN_W | Byte count, 1..128 |
| req_unlock_i | input | 1 | Prepend the three-write unlock prefix |
| req_mode_i | input | 2 | 0/3 timed wait, 1 bit-7 poll, 2 bit-6 poll |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_ready_o | output | 1 | Payload byte taken |
| byte_data_i | input | DW | Payload byte |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_addr_o | output | AW | Memory address |
| mem_dq_o | output | DW | Write data toward memory |
| mem_dq_oe_o | output | 1 | Write data drive enable |
| mem_dq_i | input | DW | Read data from memory |
| done_o | output | 1 | Request finished, one-cycle pulse |
| timeout_o | output | 1 | Request ended by poll timeout, valid with done_o |

## Verification
A bus model in the bench logs every write and reports a busy device for a set number of cycles after each write. While busy, a read returns bit 7 inverted and bit 6 toggling. Random requests cover lengths from 1 to 128, random start offsets, every mode code and both prefix choices. A short busy time shows that bit-7 polling stops on a single ready read while bit-6 polling needs a matching pair. Directed cases cover a start offset that wraps inside the page, and a busy time longer than the timeout so that the poll is abandoned. Timed mode is checked to make no reads and to wait the full interval.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;

  typedef enum logic [1:0] {
    POLL_NONE  = 2'd0,
    POLL_BIT7  = 2'd1,
    POLL_BIT6  = 2'd2,
    POLL_NONE2 = 2'd3
  } poll_mode_e;

  typedef enum logic [1:0] {
    BC_IDLE, BC_SETUP, BC_STROBE, BC_RECOV
  } bc_state_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_UNLK, SQ_UNLK_W, SQ_LOAD, SQ_LOAD_W,
    SQ_SETTLE, SQ_POLL, SQ_POLL_W, SQ_FIN
  } sq_state_e;

  localparam int UNLOCK_STEPS = 3;

  function automatic logic [15:0] unlock_addr(input logic [1:0] step);
    return (step == 2'd1) ? 16'h2AAA : 16'h5555;
  endfunction

  function automatic logic [7:0] unlock_data(input logic [1:0] step);
    case (step)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/eeprom_bus_cycle.sv
module eeprom_bus_cycle
  import eeprom_prog_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 12,
  parameter int RECOV_CYC = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          ce_no,
  output logic          oe_no,
  output logic          we_no,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i
);

  localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAXC   = (MAX_AB > RECOV_CYC) ? MAX_AB : RECOV_CYC;
  localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;

  bc_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BC_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        BC_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          rd_q    <= rd_i;
          cnt_q   <= CW'(SETUP_CYC - 1);
          st_q    <= BC_SETUP;
        end
        BC_SETUP: if (cnt_zero) begin
          cnt_q <= CW'(PULSE_CYC - 1);
          st_q  <= BC_STROBE;
        end else cnt_q <= cnt_q - 1'b1;
        BC_STROBE: if (cnt_zero) begin
          if (rd_q) rdata_q <= dq_i;
          cnt_q <= CW'(RECOV_CYC - 1);
          st_q  <= BC_RECOV;
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_zero) st_q <= BC_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign idle_o  = (st_q == BC_IDLE);
  assign done_o  = (st_q == BC_RECOV) && cnt_zero;
  assign ce_no   = !((st_q == BC_SETUP) || (st_q == BC_STROBE));
  assign we_no   = !((st_q == BC_STROBE) && !rd_q);
  assign oe_no   = !((st_q == BC_STROBE) && rd_q);
  assign dq_oe_o = (st_q != BC_IDLE) && !rd_q;
  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/eeprom_poll_eval.sv
module eeprom_poll_eval
  import eeprom_prog_pkg::*;
#(
  parameter int DW = 8
) (
  input  poll_mode_e    mode_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] ref_i,
  input  logic          prev_bit_i,
  input  logic          prev_ok_i,
  output logic          ready_o
);

  localparam int B7 = DW - 1;
  localparam int B6 = DW - 2;

  always_comb begin
    case (mode_i)
      POLL_BIT7: ready_o = (rdata_i[B7] == ref_i[B7]);
      POLL_BIT6: ready_o = prev_ok_i && (rdata_i[B6] == prev_bit_i);
      default:   ready_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog
  import eeprom_prog_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int PAGE_BITS   = 7,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 12,
  parameter int RECOV_CYC   = 12,
  parameter int SETTLE_CYC  = 1200,
  parameter int WAIT_CYC    = 1000000,
  parameter int TIMEOUT_CYC = 1500000,
  localparam int LEN_W      = PAGE_BITS + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             req_unlock_i,
  input  logic [1:0]       req_mode_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic [DW-1:0]    byte_data_i,
  output logic             mem_ce_no,
  output logic             mem_oe_no,
  output logic             mem_we_no,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe_o,
  input  logic [DW-1:0]    mem_dq_i,
  output logic             done_o,
  output logic             timeout_o
);

  localparam int TMAX_A = (WAIT_CYC > TIMEOUT_CYC) ? WAIT_CYC : TIMEOUT_CYC;
  localparam int TMAX   = (TMAX_A > SETTLE_CYC) ? TMAX_A : SETTLE_CYC;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int PGW    = AW - PAGE_BITS;

  sq_state_e            st_q;
  logic [PGW-1:0]       page_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [LEN_W-1:0]     len_q, cnt_q;
  poll_mode_e           mode_q;
  logic [1:0]           step_q;
  logic [AW-1:0]        last_addr_q;
  logic [DW-1:0]        last_data_q;
  logic [TW-1:0]        elapsed_q;
  logic                 prev_bit_q, prev_ok_q, tmo_q;

  logic                 eng_start, eng_rd, eng_idle, eng_done;
  logic [AW-1:0]        eng_addr, cur_addr;
  logic [DW-1:0]        eng_wdata, eng_rdata;
  logic                 poll_ready, timed, settle_end, tmo_hit;

  assign cur_addr   = {page_q, off_q};
  assign timed      = (mode_q == POLL_NONE) || (mode_q == POLL_NONE2);
  assign settle_end = timed ? (elapsed_q == TW'(WAIT_CYC - 1))
                            : (elapsed_q == TW'(SETTLE_CYC - 1));
  assign tmo_hit    = (elapsed_q >= TW'(TIMEOUT_CYC));

  always_comb begin
    eng_start = 1'b0;
    eng_rd    = 1'b0;
    eng_addr  = cur_addr;
    eng_wdata = byte_data_i;
    case (st_q)
      SQ_UNLK: begin
        eng_start = 1'b1;
        eng_addr  = AW'(unlock_addr(step_q));
        eng_wdata = DW'(unlock_data(step_q));
      end
      SQ_LOAD: eng_start = byte_valid_i;
      SQ_POLL: begin
        eng_start = 1'b1;
        eng_rd    = 1'b1;
        eng_addr  = last_addr_q;
      end
      default: ;
    endcase
  end

  eeprom_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .rd_i    (eng_rd),
    .addr_i  (eng_addr),
    .wdata_i (eng_wdata),
    .idle_o  (eng_idle),
    .done_o  (eng_done),
    .rdata_o (eng_rdata),
    .ce_no   (mem_ce_no),
    .oe_no   (mem_oe_no),
    .we_no   (mem_we_no),
    .addr_o  (mem_addr_o),
    .dq_o    (mem_dq_o),
    .dq_oe_o (mem_dq_oe_o),
    .dq_i    (mem_dq_i)
  );

  eeprom_poll_eval #(.DW(DW)) u_eval (
    .mode_i     (mode_q),
    .rdata_i    (eng_rdata),
    .ref_i      (last_data_q),
    .prev_bit_i (prev_bit_q),
    .prev_ok_i  (prev_ok_q),
    .ready_o    (poll_ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_IDLE;
      page_q      <= '0;
      off_q       <= '0;
      len_q       <= '0;
      cnt_q       <= '0;
      mode_q      <= POLL_NONE;
      step_q      <= '0;
      last_addr_q <= '0;
      last_data_q <= '0;
      elapsed_q   <= '0;
      prev_bit_q  <= 1'b0;
      prev_ok_q   <= 1'b0;
      tmo_q       <= 1'b0;
    end else begin
      if ((st_q == SQ_SETTLE || st_q == SQ_POLL || st_q == SQ_POLL_W) &&
          (elapsed_q != '1))
        elapsed_q <= elapsed_q + 1'b1;
      case (st_q)
        SQ_IDLE: if (req_valid_i) begin
          page_q    <= req_addr_i[AW-1:PAGE_BITS];
          off_q     <= req_addr_i[PAGE_BITS-1:0];
          len_q     <= req_len_i;
          mode_q    <= poll_mode_e'(req_mode_i);
          cnt_q     <= '0;
          step_q    <= '0;
          tmo_q     <= 1'b0;
          st_q      <= req_unlock_i ? SQ_UNLK : SQ_LOAD;
        end
        SQ_UNLK: st_q <= SQ_UNLK_W;
        SQ_UNLK_W: if (eng_done) begin
          if (step_q == 2'(UNLOCK_STEPS - 1)) st_q <= SQ_LOAD;
          else begin
            step_q <= step_q + 1'b1;
            st_q   <= SQ_UNLK;
          end
        end
        SQ_LOAD: if (byte_valid_i && eng_idle) begin
          last_addr_q <= cur_addr;
          last_data_q <= byte_data_i;
          off_q       <= off_q + 1'b1;
          cnt_q       <= cnt_q + 1'b1;
          st_q        <= SQ_LOAD_W;
        end
        SQ_LOAD_W: if (eng_done) begin
          if (cnt_q == len_q) begin
            elapsed_q <= '0;
            prev_ok_q <= 1'b0;
            st_q      <= SQ_SETTLE;
          end else st_q <= SQ_LOAD;
        end
        SQ_SETTLE: if (settle_end) st_q <= timed ? SQ_FIN : SQ_POLL;
        SQ_POLL: st_q <= SQ_POLL_W;
        SQ_POLL_W: if (eng_done) begin
          if (poll_ready) st_q <= SQ_FIN;
          else if (tmo_hit) begin
            tmo_q <= 1'b1;
            st_q  <= SQ_FIN;
          end else begin
            prev_bit_q <= eng_rdata[DW-2];
            prev_ok_q  <= 1'b1;
            st_q       <= SQ_POLL;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == SQ_IDLE);
  assign byte_ready_o = (st_q == SQ_LOAD) && eng_idle;
  assign done_o       = (st_q == SQ_FIN);
  assign timeout_o    = (st_q == SQ_FIN) && tmo_q;

endmodule

// File: rtl/eeprom_page_prog_chk.sv
module eeprom_page_prog_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          byte_ready_o,
  input logic          mem_ce_no,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic          mem_dq_oe_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_dq_o,
  input logic          done_o,
  input logic          timeout_o
);

  a_r4_strobes_need_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> (mem_we_no && mem_oe_no));

  a_r4_no_strobe_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_no && !mem_oe_no));

  a_r4_write_inputs_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && !$past(mem_we_no)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  a_r12_bus_released_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);

  a_r11_done_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_timeout_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

  a_r5_ready_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && byte_ready_o));

  a_r11_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);

endmodule

bind eeprom_page_prog eeprom_page_prog_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .byte_ready_o (byte_ready_o),
  .mem_ce_no    (mem_ce_no),
  .mem_oe_no    (mem_oe_no),
  .mem_we_no    (mem_we_no),
  .mem_dq_oe_o  (mem_dq_oe_o),
  .mem_addr_o   (mem_addr_o),
  .mem_dq_o     (mem_dq_o),
  .done_o       (done_o),
  .timeout_o    (timeout_o)
);

// File: tb/eeprom_page_prog_tb.sv
module eeprom_page_prog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SU = 2, PW = 3, RC = 2, ST = 20, WT = 300, TO = 2000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  logic        rst_n;
  logic        req_valid_i = 0, req_unlock_i = 0;
  logic [15:0] req_addr_i = 0;
  logic [7:0]  req_len_i = 0;
  logic [1:0]  req_mode_i = 0;
  logic        byte_valid_i = 0;
  logic [7:0]  byte_data_i = 0;
  logic        req_ready_o, byte_ready_o, mem_ce_no, mem_oe_no, mem_we_no;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_dq_o, rd_val;
  logic        mem_dq_oe_o, done_o, timeout_o;

  eeprom_page_prog #(
    .SETUP_CYC(SU), .PULSE_CYC(PW), .RECOV_CYC(RC),
    .SETTLE_CYC(ST), .WAIT_CYC(WT), .TIMEOUT_CYC(TO)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .req_unlock_i(req_unlock_i), .req_mode_i(req_mode_i),
    .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o), .byte_data_i(byte_data_i),
    .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
    .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(rd_val), .done_o(done_o), .timeout_o(timeout_o)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus model: logs writes, reports busy after each write
  int busy_len = 0, busy_cnt = 0;
  logic [7:0]  last_d = 0, wd = 0;
  logic [15:0] last_a = 0, wa = 0;
  logic tog = 0, we_q = 1, oe_q = 1;
  logic [15:0] la [0:299];
  logic [7:0]  ld [0:299];
  int nw = 0, nrd = 0, we_run = 0, we_hi = 0;
  int pulse_bad = 0, gap_bad = 0, bus_bad = 0, rd_addr_bad = 0;
  int last_rise = 0, first_rd = 0;
  bit last_rd_busy = 0;

  initial rd_val = 8'h00;

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt--;
    if (!mem_we_no && !mem_oe_no) bus_bad++;
    if (!mem_oe_no && mem_dq_oe_o) bus_bad++;
    if (!mem_we_no) begin
      if (we_q) begin
        if (nw > 0 && we_hi < SU + RC) gap_bad++;
        we_run = 0;
      end
      we_run++;
      wa = mem_addr_o;
      wd = mem_dq_o;
      if (mem_ce_no) bus_bad++;
    end else begin
      if (!we_q) begin
        if (we_run != PW) pulse_bad++;
        if (nw < 300) begin la[nw] = wa; ld[nw] = wd; end
        nw++;
        last_d = wd; last_a = wa;
        busy_cnt = busy_len;
        last_rise = cyc;
        we_hi = 0;
      end
      we_hi++;
    end
    if (!mem_oe_no && oe_q) begin
      nrd++;
      if (nrd == 1) first_rd = cyc;
      if (mem_addr_o != last_a) rd_addr_bad++;
      if (busy_cnt > 0) begin
        rd_val = {~last_d[7], tog, last_d[5:0]};
        tog = ~tog;
        last_rd_busy = 1;
      end else begin
        rd_val = last_d;
        last_rd_busy = 0;
      end
    end
    we_q = mem_we_no;
    oe_q = mem_oe_no;
  end

  // payload stream feeder
  logic [7:0] bytes [0:127];
  int feed_n = 0, feed_k = 0;
  bit fire = 0;
  always @(negedge clk) begin
    if (fire) feed_k++;
    fire = (feed_k < feed_n) && byte_ready_o;
    byte_valid_i = (feed_k < feed_n);
    byte_data_i = (feed_k < 128) ? bytes[feed_k] : 8'h00;
  end

  task automatic run_req(input logic [15:0] a, input int n, input bit unl,
                         input logic [1:0] m, input int busy, input bit exp_to);
    int u, bad, gap, done_c;
    bit to;
    @(posedge clk);
    busy_len = busy; nw = 0; nrd = 0; pulse_bad = 0; gap_bad = 0;
    bus_bad = 0; rd_addr_bad = 0; last_rd_busy = 0;
    for (int k = 0; k < n; k++) bytes[k] = 8'($urandom);
    feed_k = 0; fire = 0; feed_n = n;
    @(negedge clk);
    chk(req_ready_o == 1, "R11 ready before request", req_ready_o, 1);
    req_valid_i = 1; req_addr_i = a; req_len_i = 8'(n);
    req_unlock_i = unl; req_mode_i = m;
    @(negedge clk);
    req_valid_i = 0;
    chk(req_ready_o == 0, "R11 busy after accept", req_ready_o, 0);
    while (!done_o) @(negedge clk);
    done_c = cyc; to = timeout_o;
    @(negedge clk);
    chk(done_o == 0, "R11 done one cycle", done_o, 0);
    chk(req_ready_o == 1, "R11 ready after done", req_ready_o, 1);
    u = unl ? 3 : 0;
    chk(nw == u + n, "R3 write count", nw, u + n);
    if (unl) begin
      bad = 0;
      if (la[0] != 16'h5555 || ld[0] != 8'hAA) bad++;
      if (la[1] != 16'h2AAA || ld[1] != 8'h55) bad++;
      if (la[2] != 16'h5555 || ld[2] != 8'hA0) bad++;
      chk(bad == 0, "R2 unlock prefix", bad, 0);
    end
    bad = 0;
    for (int k = 0; k < n && u + k < 300; k++) begin
      if (la[u+k] != {a[15:7], 7'(a[6:0] + 7'(k))}) bad++;
      if (ld[u+k] != bytes[k]) bad++;
    end
    chk(bad == 0, "R3 payload address and data", bad, 0);
    if (!unl) chk(la[0] == a, "R2 no prefix when not asked", la[0], a);
    chk(feed_k == n, "R5 bytes consumed", feed_k, n);
    chk(pulse_bad == 0 && gap_bad == 0, "R4 write strobe timing", pulse_bad + gap_bad, 0);
    chk(bus_bad == 0, "R12 bus drive and strobes", bus_bad, 0);
    gap = done_c - last_rise;
    if (m == 2'd0 || m == 2'd3) begin
      chk(nrd == 0, "R9 timed mode makes no reads", nrd, 0);
      chk(gap >= WT && gap <= WT + RC + 3, "R9 timed wait length", gap, WT + RC);
      chk(to == 0, "R10 no timeout in timed mode", to, 0);
    end else if (exp_to) begin
      chk(to == 1, "R10 timeout flagged", to, 1);
      chk(gap >= TO, "R10 timeout not early", gap, TO);
    end else begin
      chk(to == 0, "R10 no false timeout", to, 0);
      chk(nrd > 0 && first_rd - last_rise >= ST, "R6 settle before poll",
          first_rd - last_rise, ST);
      if (m == 2'd1) begin
        chk(last_rd_busy == 0, "R7 done only on ready read", last_rd_busy, 0);
        chk(rd_addr_bad == 0, "R7 polls last address", rd_addr_bad, 0);
      end else begin
        chk(last_rd_busy == 0, "R8 done only on ready read", last_rd_busy, 0);
        chk(nrd >= 2, "R8 two matching reads", nrd, 2);
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL R11: watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1 && mem_ce_no && mem_oe_no && mem_we_no &&
        !mem_dq_oe_o && !done_o && !timeout_o, "R1 reset state",
        {req_ready_o, mem_ce_no, mem_oe_no, mem_we_no, mem_dq_oe_o, done_o}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready_o == 1 && mem_ce_no && !byte_ready_o, "R1 idle after reset",
        {req_ready_o, mem_ce_no, byte_ready_o}, 3'b110);
    // directed corners
    run_req(16'h127E, 4, 1, 2'd1, 200, 0);   // page wrap, bit-7
    run_req(16'h4000, 1, 0, 2'd1, 5, 0);     // ready on first poll
    run_req(16'h4001, 1, 0, 2'd2, 5, 0);     // bit-6 needs a pair
    run_req(16'hFF80, 128, 1, 2'd2, 300, 0); // full page, bit-6
    run_req(16'h0033, 3, 0, 2'd3, 50, 0);    // alternate timed code
    run_req(16'h8005, 2, 1, 2'd1, 5000, 1);  // poll abandoned
    run_req(16'h8006, 2, 0, 2'd2, 5000, 1);
    // random mix
    for (int i = 0; i < 10; i++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      run_req(16'($urandom), 1 + int'($urandom % 128), 1'($urandom % 2), m,
              10 + int'($urandom % 400), 0);
    end
    summary();
  end

endmodule